// File: doc/BRIEF.md
# Receive Error Status Tracker

This block holds the receive side status of a 16550-style serial port. Completed characters arrive from a receive shifter together with their parity, framing and break tags. The block stores them and presents the character at the head of its buffer, with the error tags of that character. It also keeps a data-ready flag, a sticky overrun flag and an aggregate flag that covers every stored character. The clear-on-read rules are applied here, so a register front end only needs to forward its read strobes.

Two buffering modes are supported. In queued mode, characters go into a first-in first-out store of parameterised depth, and the per-character tags follow the head entry as it is consumed. In single-buffer mode, only one character is held, and a new arrival replaces an unread one. Sampling of the serial line itself is done elsewhere.

Top module: `rx_status_tracker`

## Requirements
- R1: After reset, data_ready, overrun, fifo_err, par_err, frm_err and brk_err are 0 and head_data is 0x00.
- R2: In queued mode (fifo_mode=1), characters are presented on head_data in arrival order. data_ready is 1 while at least one unread character is stored. A data_rd pulse removes the head entry. A data_rd pulse while empty changes nothing.
- R3: par_err, frm_err and brk_err show the tags of the character currently on head_data. They change when that character is removed, and they are 0 while the store is empty.
- R4: An arrival with rx_brk=1 is stored as data 0x00 with brk_err=1, frm_err=1 and par_err=0, whatever rx_data, rx_par_err and rx_frm_err carry.
- R5: fifo_err is 1 while any stored character carries a parity, framing or break tag. It falls only when the last such character has been removed.
- R6: In queued mode with DEPTH characters stored, an arrival without a data_rd in the same cycle is discarded and overrun becomes 1 on the next cycle, leaving the stored contents unchanged. An arrival together with a data_rd is accepted.
- R7: In single-buffer mode (fifo_mode=0), one character is held. An arrival onto an unread character replaces it, including its tags, and sets overrun. A data_rd clears data_ready and the tag flags.
- R8: overrun stays 1 until a status_rd pulse, and it is 0 in the cycle after that pulse. If a new overrun event occurs in the same cycle as status_rd, overrun stays 1.
- R9: In queued mode, a fifo_clear pulse empties the store, so data_ready and fifo_err are 0 on the next cycle. A character arriving in the same cycle is kept as the only entry. overrun is not changed.
- R10: In single-buffer mode, fifo_clear has no effect on the held character or on any flag.
- R11: A change of fifo_mode empties the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_mode | input | 1 | 1 = queued mode, 0 = single-buffer mode |
| fifo_clear | input | 1 | Pulse: empty the store (queued mode only) |
| rx_valid | input | 1 | Pulse: one completed character is on rx_data |
| rx_data | input | 8 | Received character |
| rx_par_err | input | 1 | Parity tag of the arriving character |
| rx_frm_err | input | 1 | Framing tag of the arriving character |
| rx_brk | input | 1 | Line was held low for longer than a full character time |
| data_rd | input | 1 | Pulse: the data register is read |
| status_rd | input | 1 | Pulse: the status register is read |
| head_data | output | 8 | Character at the head of the store, 0x00 when empty |
| data_ready | output | 1 | At least one unread character |
| overrun | output | 1 | Sticky overrun flag |
| par_err | output | 1 | Parity tag of the head character |
| frm_err | output | 1 | Framing tag of the head character |
| brk_err | output | 1 | Break tag of the head character |
| fifo_err | output | 1 | Some stored character carries an error tag |

## Verification
A wrong read or write pointer shows up as a character on head_data that is out of order or repeated, at the first read after the fault. A stale count shows up as data_ready staying high past the last character, or as an early overrun while the store still has room. The error tally is separate from the data store, so a miscount shows up in fifo_err alone. It appears only when the last erroneous character leaves, or after a clear, which is why the checks drain the store fully after each error pattern. An overrun flag with a wrong set or clear rule differs from the expected value one cycle after the full-store arrival or the status read.

// File: rtl/rxst_pkg.sv
// Shared types for the receive error status tracker.
// Assumes an 8-bit character; the tag bits travel beside the data.
package rxst_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    function automatic logic entry_has_err(input rx_entry_t e);
        return e.brk | e.frm | e.par;
    endfunction
endpackage

// File: rtl/rxst_store.sv
// Character store: circular buffer of tagged entries with a count.
// Assumes the controller never asks for push when full (without pop),
// and that overwrite is only asked while exactly one entry is held.
// flush restarts at slot 0; a same-cycle push lands in slot 0.
module rxst_store
    import rxst_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic                         pop,
    input  logic                         overwrite,
    input  rx_entry_t                    wr_entry,
    output rx_entry_t                    head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] rd_ptr, wr_ptr, wr_addr;
    logic             wr_en;
    rx_entry_t        slot [DEPTH];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    // Pick the slot written this cycle.
    always_comb begin
        wr_en   = push | overwrite;
        wr_addr = flush ? '0 : (overwrite ? rd_ptr : wr_ptr);
    end

    // One register per slot, loaded when addressed.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == PTR_W'(g)))
                slot[g] <= wr_entry;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= push ? PTR_W'(1) : '0;
            count  <= push ? CNT_W'(1) : '0;
        end else if (!overwrite) begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head = slot[rd_ptr];
endmodule

// File: rtl/rxst_err_tally.sv
// Counts stored entries that carry any error tag; the aggregate
// flag is set while the count is non-zero. Assumes add and sub
// describe the same cycle's store traffic as the character store.
module rxst_err_tally #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic add,
    input  logic sub,
    output logic any_err
);
    localparam int CNT_W = $clog2(DEPTH+1);
    logic [CNT_W-1:0] n_err;

    // Track the number of erroneous entries held.
    always_ff @(posedge clk) begin
        if (!rst_n)     n_err <= '0;
        else if (flush) n_err <= add ? CNT_W'(1) : '0;
        else            n_err <= n_err + CNT_W'(add) - CNT_W'(sub);
    end

    assign any_err = (n_err != '0);
endmodule

// File: rtl/rxst_ovr_flag.sv
// Sticky overrun flag: set by an event, cleared by a status read;
// an event in the read cycle wins.
module rxst_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_rd,
    output logic flag
);
    // Hold the overrun indication until it is read.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_rd)  flag <= 1'b0;
    end
endmodule

// File: rtl/rx_status_tracker.sv
// Receive status tracker for a 16550-style serial port. Decides per
// cycle whether an arriving character is stored, dropped (full store
// in queued mode) or overwrites the held one (single-buffer mode),
// and derives the head tags, data-ready and aggregate error flags.
// Assumes at most one arrival per cycle and single-cycle read pulses.
module rx_status_tracker
    import rxst_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              fifo_clear,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_brk,
    input  logic              data_rd,
    input  logic              status_rd,
    output logic [CHAR_W-1:0] head_data,
    output logic              data_ready,
    output logic              overrun,
    output logic              par_err,
    output logic              frm_err,
    output logic              brk_err,
    output logic              fifo_err
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic             mode_q;
    logic             flush, has_data, full;
    logic             push, pop, overwrite, drop;
    logic             err_add, err_sub;
    logic [CNT_W-1:0] count;
    rx_entry_t        arrival, head;

    // Remember the mode so that a change can empty the store.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= fifo_mode;
    end

    // Turn the arriving character into a store entry; break is a zero char.
    always_comb begin
        if (rx_brk) arrival = '{brk: 1'b1, frm: 1'b1, par: 1'b0, data: '0};
        else        arrival = '{brk: 1'b0, frm: rx_frm_err, par: rx_par_err, data: rx_data};
    end

    // Decide store traffic for this cycle.
    always_comb begin
        flush     = (fifo_mode != mode_q) || (fifo_mode && fifo_clear);
        has_data  = (count != '0);
        full      = (count == CNT_W'(DEPTH));
        pop       = data_rd && has_data && !flush;
        push      = 1'b0;
        overwrite = 1'b0;
        drop      = 1'b0;
        if (flush) begin
            push = rx_valid;
        end else if (fifo_mode) begin
            push = rx_valid && (!full || pop);
            drop = rx_valid && full && !pop;
        end else begin
            overwrite = rx_valid && has_data && !pop;
            push      = rx_valid && !overwrite;
        end
        err_add = (push || overwrite) && entry_has_err(arrival);
        err_sub = (pop || overwrite) && entry_has_err(head);
    end

    rxst_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .pop       (pop),
        .overwrite (overwrite),
        .wr_entry  (arrival),
        .head      (head),
        .count     (count)
    );

    rxst_err_tally #(.DEPTH(DEPTH)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .add     (err_add),
        .sub     (err_sub),
        .any_err (fifo_err)
    );

    rxst_ovr_flag u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (drop || overwrite),
        .clr_rd  (status_rd),
        .flag    (overrun)
    );

    // Present the head entry, masked while empty.
    always_comb begin
        data_ready = has_data;
        head_data  = has_data ? head.data : '0;
        par_err    = has_data && head.par;
        frm_err    = has_data && head.frm;
        brk_err    = has_data && head.brk;
    end
endmodule

// File: rtl/rx_status_tracker_checker.sv
// Port-level properties of the receive status tracker.
module rx_status_tracker_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_mode,
    input logic       fifo_clear,
    input logic       rx_valid,
    input logic       data_rd,
    input logic       status_rd,
    input logic [7:0] head_data,
    input logic       data_ready,
    input logic       overrun,
    input logic       par_err,
    input logic       frm_err,
    input logic       brk_err,
    input logic       fifo_err
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!data_ready && !overrun && !fifo_err));

    a_r2_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_ready && !rx_valid) |=> !data_ready);

    a_r3_empty_no_tags: assert property (@(posedge clk) disable iff (!rst_n)
        !data_ready |-> !(par_err || frm_err || brk_err));

    a_r4_break_shape: assert property (@(posedge clk) disable iff (!rst_n)
        brk_err |-> (frm_err && !par_err && head_data == 8'h00));

    a_r5_err_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_err |-> data_ready);

    a_r8_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !status_rd) |=> overrun);

    a_r8_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !rx_valid) |=> !overrun);

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && fifo_clear && !rx_valid) |=> (!data_ready && !fifo_err));
endmodule

bind rx_status_tracker rx_status_tracker_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_mode  (fifo_mode),
    .fifo_clear (fifo_clear),
    .rx_valid   (rx_valid),
    .data_rd    (data_rd),
    .status_rd  (status_rd),
    .head_data  (head_data),
    .data_ready (data_ready),
    .overrun    (overrun),
    .par_err    (par_err),
    .frm_err    (frm_err),
    .brk_err    (brk_err),
    .fifo_err   (fifo_err)
);

// File: tb/rx_status_tracker_test.sv
module rx_status_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_mode = 1'b0, fifo_clear = 1'b0, rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
    logic       data_rd = 1'b0, status_rd = 1'b0;
    logic [7:0] head_data;
    logic       data_ready, overrun, par_err, frm_err, brk_err, fifo_err;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    rx_status_tracker uut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .fifo_clear(fifo_clear),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .data_rd(data_rd),
        .status_rd(status_rd), .head_data(head_data), .data_ready(data_ready),
        .overrun(overrun), .par_err(par_err), .frm_err(frm_err),
        .brk_err(brk_err), .fifo_err(fifo_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic p, input logic f, input logic b);
        rx_valid = 1'b1; rx_data = d; rx_par_err = p; rx_frm_err = f; rx_brk = b;
        tick();
        rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic rd();
        data_rd = 1'b1; tick(); data_rd = 1'b0;
    endtask

    task automatic rd_status();
        status_rd = 1'b1; tick(); status_rd = 1'b0;
    endtask

    task automatic clear_pulse();
        fifo_clear = 1'b1; tick(); fifo_clear = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        fifo_mode = m; tick();
    endtask

    task automatic fill(input logic [7:0] base);
        for (int i = 0; i < 16; i++) send(base + 8'(i), 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1", "data_ready", data_ready, 0);
        chk("R1", "overrun", overrun, 0);
        chk("R1", "fifo_err", fifo_err, 0);
        chk("R1", "tags", {par_err, frm_err, brk_err}, 0);
        chk("R1", "head_data", head_data, 8'h00);
    endtask

    task automatic t_order();
        set_mode(1'b1);
        send(8'h11, 0, 0, 0); send(8'h22, 0, 0, 0); send(8'h33, 0, 0, 0);
        chk("R2", "data_ready with data", data_ready, 1);
        chk("R2", "head first", head_data, 8'h11);
        rd(); chk("R2", "head second", head_data, 8'h22);
        rd(); chk("R2", "head third", head_data, 8'h33);
        rd(); chk("R2", "empty after drain", data_ready, 0);
        rd(); chk("R2", "read on empty", data_ready, 0);
        send(8'h44, 0, 0, 0);
        chk("R2", "after empty read", head_data, 8'h44);
        rd();
    endtask

    task automatic t_head_tags();
        send(8'hA1, 0, 0, 0); send(8'hB2, 1, 0, 0); send(8'hC3, 0, 1, 0);
        chk("R3", "clean head tags", {par_err, frm_err, brk_err}, 3'b000);
        chk("R5", "aggregate with errors behind", fifo_err, 1);
        rd(); chk("R3", "parity head", {par_err, frm_err, brk_err}, 3'b100);
        chk("R3", "parity head data", head_data, 8'hB2);
        rd(); chk("R3", "framing head", {par_err, frm_err, brk_err}, 3'b010);
        chk("R5", "aggregate last error", fifo_err, 1);
        rd(); chk("R3", "empty tags", {par_err, frm_err, brk_err}, 3'b000);
        chk("R5", "aggregate cleared", fifo_err, 0);
        send(8'h0F, 1, 1, 0); send(8'h1E, 0, 0, 0);
        rd(); chk("R5", "clean char left", fifo_err, 0);
        chk("R3", "clean char tags", {par_err, frm_err}, 2'b00);
        rd();
    endtask

    task automatic t_break();
        send(8'h5A, 1, 0, 1);
        chk("R4", "break data", head_data, 8'h00);
        chk("R4", "break tags", {par_err, frm_err, brk_err}, 3'b011);
        chk("R5", "break counts as error", fifo_err, 1);
        rd();
        chk("R4", "break removed", data_ready, 0);
    endtask

    task automatic t_full();
        logic ok;
        fill(8'h80);
        chk("R6", "full no overrun", overrun, 0);
        send(8'hEE, 0, 0, 0);
        chk("R6", "overrun on extra", overrun, 1);
        ok = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (head_data !== 8'h80 + 8'(i)) ok = 1'b0;
            rd();
        end
        chk("R6", "contents intact", ok, 1);
        chk("R6", "extra char dropped", data_ready, 0);
        rd_status();
        chk("R8", "status read clears", overrun, 0);
        fill(8'h60);
        data_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'hDD;
        tick();
        data_rd = 1'b0; rx_valid = 1'b0;
        chk("R6", "read+arrival no overrun", overrun, 0);
        chk("R6", "read+arrival head", head_data, 8'h61);
        for (int i = 0; i < 15; i++) rd();
        chk("R6", "accepted char at tail", head_data, 8'hDD);
        rd();
        chk("R6", "drained", data_ready, 0);
    endtask

    task automatic t_ovr_race();
        fill(8'h20);
        status_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h99;
        tick();
        status_rd = 1'b0; rx_valid = 1'b0;
        chk("R8", "event wins over read", overrun, 1);
        tick();
        chk("R8", "held without read", overrun, 1);
        rd_status();
        chk("R8", "cleared by read", overrun, 0);
    endtask

    task automatic t_clear();
        send(8'h99, 0, 0, 0);
        chk("R6", "overrun before clear", overrun, 1);
        send(8'h01, 1, 0, 0);
        clear_pulse();
        chk("R9", "clear empties", data_ready, 0);
        chk("R9", "clear drops aggregate", fifo_err, 0);
        chk("R9", "clear keeps overrun", overrun, 1);
        send(8'h03, 0, 0, 0);
        fifo_clear = 1'b1; rx_valid = 1'b1; rx_data = 8'h77; rx_par_err = 1'b1;
        tick();
        fifo_clear = 1'b0; rx_valid = 1'b0; rx_par_err = 1'b0;
        chk("R9", "arrival kept on clear", head_data, 8'h77);
        chk("R9", "arrival tag kept", {fifo_err, par_err}, 2'b11);
        rd();
        chk("R9", "only entry", data_ready, 0);
        rd_status();
    endtask

    task automatic t_single();
        send(8'h42, 0, 0, 0); send(8'h43, 0, 0, 0);
        set_mode(1'b0);
        chk("R11", "mode change empties", data_ready, 0);
        send(8'h12, 1, 0, 0);
        chk("R7", "held char", head_data, 8'h12);
        chk("R7", "held tag", {par_err, fifo_err}, 2'b11);
        send(8'h34, 0, 0, 0);
        chk("R7", "overwrite sets overrun", overrun, 1);
        chk("R7", "overwrite data", head_data, 8'h34);
        chk("R7", "overwrite tags", {par_err, fifo_err}, 2'b00);
        clear_pulse();
        chk("R10", "clear ignored data", head_data, 8'h34);
        chk("R10", "clear ignored ready", data_ready, 1);
        rd();
        chk("R7", "read clears ready", data_ready, 0);
        rd_status();
        chk("R8", "single-mode status read", overrun, 0);
        send(8'h56, 0, 1, 0);
        data_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h78;
        tick();
        data_rd = 1'b0; rx_valid = 1'b0;
        chk("R7", "read+arrival no overrun", overrun, 0);
        chk("R7", "read+arrival data", head_data, 8'h78);
        chk("R7", "read+arrival tags", frm_err, 0);
        rd();
        set_mode(1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_order();
        t_head_tags();
        t_break();
        t_full();
        t_ovr_race();
        t_clear();
        t_single();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule